// File: doc/BRIEF.md
# Vernier Time Counter and Result Bank

This block is the digital back end of a two-oscillator Vernier time-to-digital converter. A reference edge opens a coarse phase, in which periods of the slow gated oscillator are counted. The feedback edge closes that phase, captures the lead/lag sign from the external pre-logic and opens a fine phase. In the fine phase, periods of the fast oscillator are counted until the external arbiter reports that the fast edge has caught the slow one. The two counts form one time word in units of the fine step, which is the slow-minus-fast period difference: `Nc * SLOW_RATIO + Nf`, saturated to the code width. Here `SLOW_RATIO` is the slow period expressed in fine steps.

The word is published on a magnitude bus, a sign output and a signed two's-complement control bus, and only when a read strobe arrives. If the arbiter stays silent until the fine count reaches a limit set at a port, the measurement ends with a timeout flag and a full-scale code. All oscillator, arbiter and edge events reach the block as single-cycle strobes in the system clock domain.

The controller has four states:
- `ST_IDLE` goes to `ST_COARSE` on a reference start, which clears both counters.
- `ST_COARSE` goes to `ST_FINE` on a feedback stop.
- `ST_FINE` goes to `ST_READY` when the arbiter catch-up arrives, or when the fine limit is reached.
- `ST_READY` goes to `ST_IDLE` on a read strobe, which loads the result bank.

Top module: `vtdc_count_eval`

## Requirements
- R1: After reset: `busy` and `timeout` are 0, `out_code`, `out_sign` and `ctl_word` are 0, and the controller is idle.
- R2: `ref_start` is accepted only while idle. It clears both counters, and `busy` is 1 from the next cycle until the fine phase ends. A start in any other state has no effect.
- R3: In the coarse phase, every `slow_tick` cycle adds one to the coarse count, except a cycle in which `fb_stop` is also high. `slow_tick` outside the coarse phase is ignored.
- R4: `fb_stop` during the coarse phase ends it, samples `sign_in` and starts the fine phase.
- R5: In the fine phase, every `fast_tick` cycle adds one to the fine count, except a cycle in which `catch_up` is high. `catch_up` ends the phase, and `busy` is 0 from the next cycle.
- R6: The result code is `Nc*SLOW_RATIO + Nf`, clamped to `2^CODE_W - 1` (2047 by default).
- R7: A counted fast tick that brings the fine count to `fine_limit` without a catch-up ends the phase and sets `timeout` to 1. The code then becomes 2047. `timeout` returns to 0 on the next accepted start.
- R8: `out_code`, `out_sign` and `ctl_word` change only on a `read_stb` received while a result is ready. A read in any other state leaves them as they were.
- R9: `ctl_word` is the code as a signed `CODE_W+1`-bit two's-complement number. It is negated when the sign is 1, and sign 1 means the feedback edge led the reference edge.
- R10: A finished result waits in the ready state until read; a `ref_start` given before the read is ignored and the result is not lost. After the read, the controller is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_start | input | 1 | Reference edge strobe, opens a measurement |
| fb_stop | input | 1 | Feedback edge strobe, closes the coarse phase |
| slow_tick | input | 1 | One slow-oscillator period elapsed |
| fast_tick | input | 1 | One fast-oscillator period elapsed |
| catch_up | input | 1 | Arbiter reports fast edge caught slow edge |
| sign_in | input | 1 | Lead/lag bit, 1 = feedback led |
| read_stb | input | 1 | Loads the result bank |
| fine_limit | input | CNT_W | Fine count at which the timeout fires |
| busy | output | 1 | Measurement in progress |
| timeout | output | 1 | Last measurement ended without catch-up |
| out_code | output | CODE_W | Published magnitude in fine steps |
| out_sign | output | 1 | Published sign |
| ctl_word | output | CODE_W+1 | Published signed two's-complement time word |

## Verification
The table of measurements covers the following cases, and each one separates a different fault:
- Coarse-only, fine-only and mixed counts show whether the slow count carries the ratio weight and the fine count carries unit weight.
- Positive and negative signs check the negation on the control bus.
- Sums landing exactly on 2047 and beyond it show whether the clamp is placed correctly.
- Fine counts one short of the limit and exactly at it check the timeout boundary.

Directed sequences cover the remaining cases:
- A slow tick coincident with the stop, and a slow tick during the fine phase, must both be left out of the count.
- Reads before a result exists, or while busy, must change nothing.
- A start arriving while a result is still unread must not destroy that result.

// File: rtl/vtdc_eval_pkg.sv
package vtdc_eval_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_COARSE = 2'd1,
        ST_FINE   = 2'd2,
        ST_READY  = 2'd3
    } vtdc_state_t;
endpackage

// File: rtl/vtdc_sat_counter.sv
module vtdc_sat_counter #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc && (cnt != TOP)) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/vtdc_calc.sv
module vtdc_calc #(
    parameter int CNT_W      = 11,
    parameter int CODE_W     = 11,
    parameter int SLOW_RATIO = 8
) (
    input  logic [CNT_W-1:0]  coarse,
    input  logic [CNT_W-1:0]  fine,
    input  logic              force_max,
    input  logic              sign,
    output logic [CODE_W-1:0] code,
    output logic [CODE_W:0]   ctl
);
    localparam int RW = $clog2(SLOW_RATIO + 1);
    localparam int PW = ((CNT_W > CODE_W) ? CNT_W : CODE_W) + RW + 1;
    localparam logic [CODE_W-1:0] MAXC = {CODE_W{1'b1}};

    logic [PW-1:0]   sum;
    logic [CODE_W:0] mag;

    always_comb begin
        sum  = PW'(coarse) * PW'(SLOW_RATIO) + PW'(fine);
        if (force_max || (sum > PW'(MAXC))) begin
            code = MAXC;
        end else begin
            code = sum[CODE_W-1:0];
        end
        mag = {1'b0, code};
        ctl = sign ? (~mag + 1'b1) : mag;
    end
endmodule

// File: rtl/vtdc_count_eval.sv
module vtdc_count_eval
    import vtdc_eval_pkg::*;
#(
    parameter int CODE_W     = 11,
    parameter int SLOW_RATIO = 8,
    parameter int CNT_W      = CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_start,
    input  logic              fb_stop,
    input  logic              slow_tick,
    input  logic              fast_tick,
    input  logic              catch_up,
    input  logic              sign_in,
    input  logic              read_stb,
    input  logic [CNT_W-1:0]  fine_limit,
    output logic              busy,
    output logic              timeout,
    output logic [CODE_W-1:0] out_code,
    output logic              out_sign,
    output logic [CODE_W:0]   ctl_word
);
    localparam logic [CODE_W-1:0] MAXC = {CODE_W{1'b1}};

    vtdc_state_t       state_q, state_d;
    logic [CNT_W-1:0]  coarse_cnt, fine_cnt;
    logic [CNT_W:0]    fine_next;
    logic              start_acc, stop_acc, catch_acc, read_acc;
    logic              coarse_inc, fine_inc, limit_hit;
    logic              sign_q, timeout_q;
    logic [CODE_W-1:0] code_calc;
    logic [CODE_W:0]   ctl_calc;

    // qualified events
    always_comb begin
        start_acc  = (state_q == ST_IDLE)   && ref_start;
        stop_acc   = (state_q == ST_COARSE) && fb_stop;
        coarse_inc = (state_q == ST_COARSE) && slow_tick && !fb_stop;
        catch_acc  = (state_q == ST_FINE)   && catch_up;
        fine_inc   = (state_q == ST_FINE)   && fast_tick && !catch_up;
        fine_next  = {1'b0, fine_cnt} + 1'b1;
        limit_hit  = fine_inc && (fine_next >= {1'b0, fine_limit});
        read_acc   = (state_q == ST_READY)  && read_stb;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (ref_start)              state_d = ST_COARSE;
            ST_COARSE: if (fb_stop)                state_d = ST_FINE;
            ST_FINE:   if (catch_up || limit_hit)  state_d = ST_READY;
            ST_READY:  if (read_stb)               state_d = ST_IDLE;
            default:                               state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    vtdc_sat_counter #(.W(CNT_W)) u_coarse (
        .clk(clk), .rst_n(rst_n), .clr(start_acc), .inc(coarse_inc), .cnt(coarse_cnt)
    );

    vtdc_sat_counter #(.W(CNT_W)) u_fine (
        .clk(clk), .rst_n(rst_n), .clr(start_acc), .inc(fine_inc), .cnt(fine_cnt)
    );

    vtdc_calc #(.CNT_W(CNT_W), .CODE_W(CODE_W), .SLOW_RATIO(SLOW_RATIO)) u_calc (
        .coarse(coarse_cnt), .fine(fine_cnt), .force_max(timeout_q),
        .sign(sign_q), .code(code_calc), .ctl(ctl_calc)
    );

    // flags and result bank
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sign_q    <= 1'b0;
            timeout_q <= 1'b0;
            out_code  <= '0;
            out_sign  <= 1'b0;
            ctl_word  <= '0;
        end else begin
            if (stop_acc)       sign_q    <= sign_in;
            if (start_acc)      timeout_q <= 1'b0;
            else if (limit_hit) timeout_q <= 1'b1;
            if (read_acc) begin
                out_code <= code_calc;
                out_sign <= sign_q;
                ctl_word <= ctl_calc;
            end
        end
    end

    always_comb begin
        busy    = (state_q == ST_COARSE) || (state_q == ST_FINE);
        timeout = timeout_q;
    end

    // R2
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_acc |=> (coarse_cnt == '0 && fine_cnt == '0 && busy));

    // R3
    coarse_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FINE) |=> $stable(coarse_cnt));

    // R5
    catch_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        catch_acc |=> (state_q == ST_READY && !busy));

    // R7
    timeout_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READY && timeout_q) |-> (code_calc == MAXC));

    // R8
    bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !read_acc |=> ($stable(out_code) && $stable(ctl_word) && $stable(out_sign)));

    // R10
    ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READY && !read_stb) |=> (state_q == ST_READY));
endmodule

// File: tb/vtdc_count_eval_tb.sv
module vtdc_count_eval_tb;
    localparam int CODE_W = 11;
    localparam int RATIO  = 8;
    localparam int MAXC   = 2047;
    localparam int NV     = 9;
    // nc, nf, sign, limit
    localparam int VEC [NV][4] = '{
        '{3,   5,  0, 100},
        '{0,   0,  1, 100},
        '{10,  7,  1, 100},
        '{0,   40, 0, 100},
        '{255, 7,  0, 100},
        '{300, 0,  1, 100},
        '{1,   19, 0, 20},
        '{1,   20, 1, 20},
        '{2,   50, 0, 20}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic ref_start = 0, fb_stop = 0, slow_tick = 0, fast_tick = 0;
    logic catch_up = 0, sign_in = 0, read_stb = 0;
    logic [10:0] fine_limit = 11'd100;
    logic busy, timeout, out_sign;
    logic [10:0] out_code;
    logic [11:0] ctl_word;
    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    vtdc_count_eval u_dut (
        .clk(clk), .rst_n(rst_n), .ref_start(ref_start), .fb_stop(fb_stop),
        .slow_tick(slow_tick), .fast_tick(fast_tick), .catch_up(catch_up),
        .sign_in(sign_in), .read_stb(read_stb), .fine_limit(fine_limit),
        .busy(busy), .timeout(timeout), .out_code(out_code),
        .out_sign(out_sign), .ctl_word(ctl_word)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_start();  ref_start = 1; @(negedge clk); ref_start = 0; endtask
    task automatic do_read();   read_stb  = 1; @(negedge clk); read_stb  = 0; endtask
    task automatic do_catch();  catch_up  = 1; @(negedge clk); catch_up  = 0; endtask
    task automatic do_stop(input bit s);
        fb_stop = 1; sign_in = s; @(negedge clk); fb_stop = 0; sign_in = 0;
    endtask
    task automatic slow_n(input int n);
        for (int i = 0; i < n; i++) begin slow_tick = 1; @(negedge clk); slow_tick = 0; @(negedge clk); end
    endtask
    task automatic fast_n(input int n);
        for (int i = 0; i < n; i++) begin fast_tick = 1; @(negedge clk); fast_tick = 0; end
    endtask

    function automatic int expect_code(int nc, int nf, int lim);
        int v;
        if (nf >= lim) return MAXC;
        v = nc * RATIO + nf;
        return (v > MAXC) ? MAXC : v;
    endfunction

    task automatic check_out(input int code, input bit s, input string tag);
        check({tag, " R6 code"}, int'(out_code), code);
        check({tag, " R9 sign"}, int'(out_sign), int'(s));
        check({tag, " R9 ctl"}, int'($signed(ctl_word)), s ? -code : code);
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1 busy", int'(busy), 0);
        check("R1 timeout", int'(timeout), 0);
        check("R1 code", int'(out_code), 0);
        check("R1 ctl", int'(ctl_word), 0);
        // R8 read with no result ready
        do_read();
        check("R8 idle read", int'(out_code), 0);

        // vector table
        for (int v = 0; v < NV; v++) begin
            int nc, nf, lim, exp_c;
            bit sg;
            nc = VEC[v][0]; nf = VEC[v][1]; sg = VEC[v][2][0]; lim = VEC[v][3];
            fine_limit = 11'(lim);
            exp_c = expect_code(nc, nf, lim);
            do_start();
            check("R2 busy", int'(busy), 1);
            slow_n(nc);
            do_stop(sg);
            fast_n(nf);
            if (nf < lim) do_catch();
            check("R5 busy low", int'(busy), 0);
            check("R7 timeout", int'(timeout), (nf >= lim) ? 1 : 0);
            do_read();
            check_out(exp_c, sg, "vec");
        end

        // R7 timeout cleared by next start; R3 coincident and late slow ticks
        fine_limit = 11'd100;
        do_start();
        check("R7 clear", int'(timeout), 0);
        slow_n(2);
        fb_stop = 1; slow_tick = 1; @(negedge clk); fb_stop = 0; slow_tick = 0;
        slow_n(3);          // R3 ignored in fine phase
        fast_n(1);
        do_catch();
        do_read();
        check_out(17, 0, "R3 R4");

        // R10 start while result unread is ignored
        do_start();
        slow_n(4);
        do_stop(1);
        fast_n(3);
        do_catch();
        do_start();
        slow_n(2);
        check("R10 busy", int'(busy), 0);
        check("R8 unread", int'(out_code), 17);
        do_read();
        check_out(35, 1, "R10");

        // R8 read while busy has no effect
        do_start();
        do_read();
        check("R8 busy read", int'(out_code), 35);
        slow_n(1);
        do_stop(0);
        fast_n(2);
        do_catch();
        do_read();
        check_out(10, 0, "R2 R5");

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule